// File: doc/BRIEF.md
# I2C Multi-Master Arbitration Monitor

This block sits beside an I2C engine. It watches the shared open-drain bus while the local controller sends as a master. The SCL and SDA line levels arrive asynchronously and pass through a synchronizer. A rising edge on the synchronized SCL produces one compare strobe. On that strobe the block checks the bus against the data bit the engine wants to send. A loss occurs when the engine released SDA (bit 1) but the bus reads low, which means another master is pulling the wired-AND line down. On a loss the block sets a sticky flag, drops the local master and transmit mode bits, and withdraws both of its pull-low enables. This leaves the controller as a slave receiver, and the winning master's transfer carries on undisturbed.

The engine supplies the data bit, an SCL pull-low request and a transfer-active qualifier. Software loads the mode bits through a write strobe. Software clears the flag with one of three strobes: a data-buffer read, a data-buffer write, or a write to the second control register. The block has no data stream. Every pin is a plain level or a one-cycle strobe, so the block needs no valid/ready handshake and has no back-pressure.

Top module: `i2c_arb_monitor`

## Requirements
- R1: After reset, `arb_lost`, `mst_mode`, `trx_mode`, `sda_pull_en` and `scl_pull_en` are all 0.
- R2: Both line inputs pass through SYNC_STAGES flops (default 2). A raw SCL rise with a mismatch present shows in `arb_lost` after the third rising clock edge that follows it, and not before. Each SCL rise yields exactly one compare strobe.
- R3: With `mst_mode`=1, `trx_mode`=1 and `xfer_active`=1, a compare strobe where the synchronized SDA is 0 and `sda_out_bit` is 1 sets `arb_lost` to 1.
- R4: When the bus matches the sent bits, no loss is flagged, even across several consecutive words.
- R5: No compare takes effect while `mst_mode`, `trx_mode` or `xfer_active` is 0.
- R6: The clock edge that sets `arb_lost` also clears `mst_mode` and `trx_mode` to 0.
- R7: `arb_lost` holds at 1 until a cycle with `dbr_rd`, `dbr_wr` or `cr2_wr` high. It reads 0 after that edge.
- R8: If a loss and a clear strobe fall in the same cycle, `arb_lost` ends at 1.
- R9: `sda_pull_en` = `mst_mode` AND NOT `sda_out_bit`. `scl_pull_en` = `mst_mode` AND `scl_drive_req`, and is forced to 0 in the cycle a loss is detected. After a loss both stay 0 until software sets `mst_mode` again.
- R10: `cfg_wr` loads `cfg_mst` and `cfg_trx` into the mode bits at the next edge. A loss in the same cycle wins, and both bits become 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Raw SCL line level |
| sda_in | input | 1 | Raw SDA line level |
| sda_out_bit | input | 1 | Engine's SDA bit (1 = release) |
| scl_drive_req | input | 1 | Engine asks to hold SCL low |
| xfer_active | input | 1 | Engine has a data transfer in progress |
| cfg_wr | input | 1 | Mode bit write strobe |
| cfg_mst | input | 1 | Master bit value for `cfg_wr` |
| cfg_trx | input | 1 | Transmit bit value for `cfg_wr` |
| dbr_rd | input | 1 | Data buffer read strobe (clears flag) |
| dbr_wr | input | 1 | Data buffer write strobe (clears flag) |
| cr2_wr | input | 1 | Control register 2 write strobe (clears flag) |
| arb_lost | output | 1 | Sticky arbitration-lost flag |
| mst_mode | output | 1 | Master mode bit |
| trx_mode | output | 1 | Transmit mode bit |
| sda_pull_en | output | 1 | 1 pulls SDA low |
| scl_pull_en | output | 1 | 1 pulls SCL low |

## Verification
The embedded properties check the following on every cycle:
- a strobe from the edge detector never repeats on the next cycle;
- a detected loss always sets the flag and clears both mode bits one edge later;
- the flag rises only when the compare was enabled;
- the flag stays put without a clear and drops after an uncontested clear;
- neither pull enable is ever active while the master bit is 0.

Some behaviour can only be shown by the bench's scenarios:
- the exact three-edge latency from a raw SCL rise;
- the first losing bit position within random contending bytes;
- identical words passing without a flag;
- the tie between set and clear, and the tie between loss and mode write;
- the drive enables resuming after software re-arms the master bit.

// File: rtl/arb_pkg.sv
package arb_pkg;
  localparam int SYNC_STAGES_DEF = 2;
  localparam int LINE_CNT        = 2;
  localparam int LINE_SCL        = 0;
  localparam int LINE_SDA        = 1;

  typedef struct packed {
    logic mst;
    logic trx;
  } mode_t;
endpackage

// File: rtl/arb_line_sync.sv
module arb_line_sync #(
  parameter int STAGES = 2,
  parameter int LINES  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] raw_i,
  output logic [LINES-1:0] sync_o
);
  localparam int LAST = STAGES - 1;

  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic [STAGES-1:0] chain_q;
    // idle bus is high, so the chain resets to released
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '1;
      else        chain_q <= {chain_q[STAGES-2:0], raw_i[g]};
    end
    assign sync_o[g] = chain_q[LAST];
  end

  initial begin
    assert (STAGES >= 2) else $error("synchronizer needs two or more stages");
  end
endmodule

// File: rtl/arb_edge_det.sv
module arb_edge_det (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_s,
  output logic rise_o
);
  logic prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b1;
    else        prev_q <= scl_s;
  end

  assign rise_o = scl_s & ~prev_q;

  // one compare strobe per SCL rise
  p_single_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rise_o |=> !rise_o);
endmodule

// File: rtl/arb_loss_detect.sv
module arb_loss_detect
  import arb_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  rise_i,
  input  logic  sda_s,
  input  logic  sda_out_bit,
  input  logic  xfer_active,
  input  mode_t mode_i,
  input  logic  clr_i,
  output logic  loss_o,
  output logic  lost_o
);
  logic cmp_en;
  logic lost_q;

  assign cmp_en = mode_i.mst & mode_i.trx & xfer_active;
  // wired-AND: released locally but bus reads low
  assign loss_o = rise_i & cmp_en & sda_out_bit & ~sda_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      lost_q <= 1'b0;
    else if (loss_o) lost_q <= 1'b1;   // set beats clear
    else if (clr_i)  lost_q <= 1'b0;
  end

  assign lost_o = lost_q;

  p_set_on_loss_r3: assert property (@(posedge clk) disable iff (!rst_n)
    loss_o |=> lost_o);
  p_only_when_enabled_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lost_o) |-> $past(mode_i.mst && mode_i.trx && xfer_active));
  p_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    lost_o && !clr_i |=> lost_o);
  p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    lost_o && clr_i && !loss_o |=> !lost_o);
endmodule

// File: rtl/arb_mode_reg.sv
module arb_mode_reg
  import arb_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  loss_i,
  input  logic  cfg_wr,
  input  logic  cfg_mst,
  input  logic  cfg_trx,
  output mode_t mode_o
);
  mode_t mode_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      mode_q <= '0;
    else if (loss_i) mode_q <= '0;           // fall back to slave receiver
    else if (cfg_wr) mode_q <= '{mst: cfg_mst, trx: cfg_trx};
  end

  assign mode_o = mode_q;

  p_fallback_r6: assert property (@(posedge clk) disable iff (!rst_n)
    loss_i |=> (!mode_o.mst && !mode_o.trx));
  p_load_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr && !loss_i |=> (mode_o.mst == $past(cfg_mst)) && (mode_o.trx == $past(cfg_trx)));
endmodule

// File: rtl/i2c_arb_monitor.sv
module i2c_arb_monitor
  import arb_pkg::*;
#(
  parameter int SYNC_STAGES = SYNC_STAGES_DEF
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  input  logic sda_out_bit,
  input  logic scl_drive_req,
  input  logic xfer_active,
  input  logic cfg_wr,
  input  logic cfg_mst,
  input  logic cfg_trx,
  input  logic dbr_rd,
  input  logic dbr_wr,
  input  logic cr2_wr,
  output logic arb_lost,
  output logic mst_mode,
  output logic trx_mode,
  output logic sda_pull_en,
  output logic scl_pull_en
);
  logic [LINE_CNT-1:0] raw_lines;
  logic [LINE_CNT-1:0] sync_lines;
  logic                scl_rise;
  logic                loss_now;
  logic                clr_any;
  mode_t               mode;

  assign raw_lines[LINE_SCL] = scl_in;
  assign raw_lines[LINE_SDA] = sda_in;
  assign clr_any = dbr_rd | dbr_wr | cr2_wr;

  arb_line_sync #(.STAGES(SYNC_STAGES), .LINES(LINE_CNT)) u_sync (
    .clk(clk), .rst_n(rst_n), .raw_i(raw_lines), .sync_o(sync_lines));

  arb_edge_det u_edge (
    .clk(clk), .rst_n(rst_n), .scl_s(sync_lines[LINE_SCL]), .rise_o(scl_rise));

  arb_loss_detect u_loss (
    .clk(clk), .rst_n(rst_n), .rise_i(scl_rise), .sda_s(sync_lines[LINE_SDA]),
    .sda_out_bit(sda_out_bit), .xfer_active(xfer_active), .mode_i(mode),
    .clr_i(clr_any), .loss_o(loss_now), .lost_o(arb_lost));

  arb_mode_reg u_mode (
    .clk(clk), .rst_n(rst_n), .loss_i(loss_now), .cfg_wr(cfg_wr),
    .cfg_mst(cfg_mst), .cfg_trx(cfg_trx), .mode_o(mode));

  assign mst_mode    = mode.mst;
  assign trx_mode    = mode.trx;
  assign sda_pull_en = mode.mst & ~sda_out_bit;
  // clock drive stops in the very cycle the loss is seen
  assign scl_pull_en = mode.mst & scl_drive_req & ~loss_now;

  p_quiet_as_slave_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !mst_mode |-> (!sda_pull_en && !scl_pull_en));
  p_release_after_loss_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(arb_lost) |-> (!scl_pull_en && !sda_pull_en));
endmodule

// File: tb/i2c_arb_monitor_tb_top.sv
module i2c_arb_monitor_tb_top;
  localparam time CLK_PERIOD = 10ns;

  logic clk = 1'b0;
  logic rst_n, scl_in, sda_in, sda_out_bit, scl_drive_req, xfer_active;
  logic cfg_wr, cfg_mst, cfg_trx, dbr_rd, dbr_wr, cr2_wr;
  logic arb_lost, mst_mode, trx_mode, sda_pull_en, scl_pull_en;
  int   n_run = 0, n_fail = 0;
  bit   done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_arb_monitor dut_i (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
    .sda_out_bit(sda_out_bit), .scl_drive_req(scl_drive_req),
    .xfer_active(xfer_active), .cfg_wr(cfg_wr), .cfg_mst(cfg_mst),
    .cfg_trx(cfg_trx), .dbr_rd(dbr_rd), .dbr_wr(dbr_wr), .cr2_wr(cr2_wr),
    .arb_lost(arb_lost), .mst_mode(mst_mode), .trx_mode(trx_mode),
    .sda_pull_en(sda_pull_en), .scl_pull_en(scl_pull_en));

  task automatic tick(int n = 1);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // bit index (MSB first) where the local byte first loses, 8 if never
  function automatic int first_loss(logic [7:0] ours, logic [7:0] theirs);
    for (int i = 7; i >= 0; i--)
      if (ours[i] && !theirs[i]) return 7 - i;
    return 8;
  endfunction

  task automatic arm(logic m, logic t);
    cfg_wr = 1; cfg_mst = m; cfg_trx = t; tick(); cfg_wr = 0;
  endtask

  task automatic send_byte(logic [7:0] ours, logic [7:0] theirs, int loss_at);
    for (int i = 0; i < 8; i++) begin
      logic ob = ours[7-i];
      logic tb = theirs[7-i];
      sda_out_bit = ob; scl_in = 0; scl_drive_req = 1;
      sda_in = (i > loss_at) ? tb : (ob & tb);
      tick(4);
      chk("R9", "scl drive while low", scl_pull_en, (i <= loss_at) ? 1 : 0);
      scl_in = 1; scl_drive_req = 0;
      tick(4);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    if (!done) $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    rst_n = 0; scl_in = 1; sda_in = 1; sda_out_bit = 1; scl_drive_req = 0;
    xfer_active = 0; cfg_wr = 0; cfg_mst = 0; cfg_trx = 0;
    dbr_rd = 0; dbr_wr = 0; cr2_wr = 0;
    tick(3);
    rst_n = 1;
    tick();
    chk("R1", "flag", arb_lost, 0);
    chk("R1", "mst", mst_mode, 0);
    chk("R1", "trx", trx_mode, 0);
    chk("R1", "enables", {sda_pull_en, scl_pull_en}, 0);

    // R10: mode write
    arm(1, 1);
    chk("R10", "mode load", {mst_mode, trx_mode}, 2'b11);
    xfer_active = 1;

    // R2/R3/R6/R9: exact latency of a loss
    scl_in = 0; sda_in = 0; sda_out_bit = 1; scl_drive_req = 1; tick(4);
    scl_in = 1; tick();
    chk("R2", "flag after 1 edge", arb_lost, 0);
    tick();
    chk("R2", "flag after 2 edges", arb_lost, 0);
    chk("R9", "scl released in detect cycle", scl_pull_en, 0);
    tick();
    chk("R3", "flag after 3 edges", arb_lost, 1);
    chk("R6", "mode cleared", {mst_mode, trx_mode}, 0);
    sda_out_bit = 0;
    chk("R9", "enables off after loss", {sda_pull_en, scl_pull_en}, 0);
    tick(5);
    chk("R7", "flag sticky", arb_lost, 1);
    chk("R9", "still off", {sda_pull_en, scl_pull_en}, 0);
    dbr_rd = 1; tick(); dbr_rd = 0;
    chk("R7", "clear by data read", arb_lost, 0);
    arm(1, 1);
    chk("R9", "drive resumes", {sda_pull_en, scl_pull_en}, 2'b11);

    // R5: disabled compares
    sda_out_bit = 1; scl_drive_req = 0;
    arm(1, 0);
    scl_in = 0; sda_in = 0; tick(4); scl_in = 1; tick(4);
    chk("R5", "no flag with trx=0", arb_lost, 0);
    arm(1, 1); xfer_active = 0;
    scl_in = 0; tick(4); scl_in = 1; tick(4);
    chk("R5", "no flag when idle", arb_lost, 0);
    chk("R5", "mode kept", {mst_mode, trx_mode}, 2'b11);
    xfer_active = 1;

    // R8: set and clear together
    scl_in = 0; tick(4); scl_in = 1; tick(2);
    cr2_wr = 1; tick(); cr2_wr = 0;
    chk("R8", "set wins over clear", arb_lost, 1);
    dbr_wr = 1; tick(); dbr_wr = 0;
    chk("R7", "clear by data write", arb_lost, 0);

    // R10: loss beats mode write
    arm(1, 1);
    scl_in = 0; tick(4); scl_in = 1; tick(2);
    cfg_wr = 1; cfg_mst = 1; cfg_trx = 1; tick(); cfg_wr = 0;
    chk("R10", "loss beats write", {mst_mode, trx_mode}, 0);
    cr2_wr = 1; tick(); cr2_wr = 0;
    chk("R7", "clear by cr2 write", arb_lost, 0);

    // R4: identical words back to back
    arm(1, 1);
    send_byte(8'hA5, 8'hA5, 8);
    send_byte(8'hFF, 8'hFF, 8);
    chk("R4", "no loss on identical words", arb_lost, 0);
    chk("R4", "still master", mst_mode, 1);

    // random contention
    for (int k = 0; k < 40; k++) begin
      logic [7:0] ours   = 8'($urandom);
      logic [7:0] theirs = ($urandom_range(0, 1) == 1) ? ours : 8'($urandom);
      int at = first_loss(ours, theirs);
      send_byte(ours, theirs, at);
      chk((at < 8) ? "R3" : "R4", "flag after byte", arb_lost, (at < 8) ? 1 : 0);
      chk("R6", "master after byte", mst_mode, (at < 8) ? 0 : 1);
      if (at < 8) begin
        case ($urandom_range(0, 2))
          0: dbr_rd = 1;
          1: dbr_wr = 1;
          default: cr2_wr = 1;
        endcase
        tick(); dbr_rd = 0; dbr_wr = 0; cr2_wr = 0;
        chk("R7", "random clear", arb_lost, 0);
        arm(1, 1);
      end
    end

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule